// File: doc/BRIEF.md
# Joint Code/Data Translation Buffer

This block keeps 256 address translations for both instruction and data accesses. They are organised as 128 sets of two ways. Software maintains the entries through four registers: two descriptor registers, a slot-index register and a command register. It loads a descriptor pair, then issues commands that search for a mapping, pick a free slot, store the pair into the selected slot or fetch a stored slot back. To remove a mapping, software stores an all-zero descriptor pair over it.

A separate lookup port takes a virtual page number and an address-space identifier. In the same cycle it returns hit, the physical frame, the seven permission and cache flags, and a flag for more than one match. Each command finishes at the clock edge that accepts it, so commands can be issued back to back.

Top module: `jtlb_engine`

## Requirements
- R1: After reset, descriptor 0 and descriptor 1 read 0, the slot-index register reads 0x8000_0000 (error flag set), every slot is invalid so every lookup misses, and `busy` is low.
- R2: Register writes are selected by `regSel`: 0 loads descriptor 0 (all 32 bits), 1 loads descriptor 1 (all 32 bits), 2 loads the slot-index register, 3 issues a command. A slot-index write keeps only bit 31 (error flag) and bits [7:0]; bits [30:8] read 0. The command code is `regWrData[2:0]`: 1 store, 2 fetch, 3 search, 4 pick-slot. Codes 0, 5, 6 and 7 change nothing.
- R3: Slot number bits [7:1] give the set and bit 0 gives the way. The set of a descriptor or lookup comes from virtual address bits [19:13], which are the low seven bits of the virtual page number.
- R4: A stored descriptor 0 matches a (page, identifier) pair only if all three hold: its valid bit 10 is set, its bits [31:13] equal the page, and either its global bit 8 is set or its bits [7:0] equal the identifier.
- R5: A search that finds exactly one matching way loads the slot-index register with that slot number and error flag 0. Both descriptor registers stay unchanged.
- R6: A search with no match loads 0x8000_0000. A search with two matching ways loads 0x8000_0001.
- R7: A store copies both descriptor registers into the selected slot. An all-zero pair erases the slot. A store while the error flag is set leaves every slot unchanged. A store changes none of the three registers.
- R8: A fetch loads both descriptor registers from the selected slot. It is ignored while the error flag is set. The slot-index register is not changed.
- R9: Pick-slot uses the set of descriptor 0 and clears the error flag. It takes way 0 if way 0 is invalid, otherwise way 1 if way 1 is invalid. If both ways are valid it takes the way named by that set's rotation bit and then inverts that bit. Rotation bits reset to 0.
- R10: The lookup port reports hit when either way matches and multi when both match. It returns frame = descriptor 1 bits [31:13] and flags = descriptor 1 bits [8:2] of the matching way, taking way 0 when both match. All of this is combinational.
- R11: Each command's result is visible after the clock edge that accepts it. `busy` stays low. Commands on consecutive cycles each take effect in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 2 | Register select (0 desc0, 1 desc1, 2 slot index, 3 command) |
| regWrData | input | 32 | Register write data / command code |
| pd0Out | output | 32 | Descriptor 0 register |
| pd1Out | output | 32 | Descriptor 1 register |
| indexOut | output | 32 | Slot-index register |
| busy | output | 1 | Always low; commands take one cycle |
| lkVpn | input | 19 | Lookup virtual page number |
| lkAsid | input | 8 | Lookup address-space identifier |
| lkHit | output | 1 | Lookup hit |
| lkMulti | output | 1 | Both ways of the set matched |
| lkPfn | output | 19 | Physical frame of the hit |
| lkPerm | output | 7 | Flags of the hit (descriptor 1 bits [8:2]) |

## Verification
The bench fills one set past its two ways so the victim choice must follow the rotation bit. A design that ignored the rotation bit would evict the same way again. One that did not prefer invalid ways would evict a live mapping while a free slot existed. The bench forces the same mapping into both ways. A design that encoded duplicates wrongly would report a plain miss or a bogus slot number instead of 0x8000_0001. The bench stores, fetches and erases while the error flag is set, to catch a design that quietly writes slot 0 or slot n. It also matches global entries against foreign identifiers, to catch a design that compares identifiers on global entries.

// File: rtl/jtlb_pkg.sv
package jtlb_pkg;
  localparam int PD_W      = 32;
  localparam int PAGE_LSB  = 13;
  localparam int VPN_W     = PD_W - PAGE_LSB;
  localparam int ASID_W    = 8;
  localparam int BIT_GLB   = 8;
  localparam int BIT_VLD   = 10;
  localparam int ERR_BIT   = 31;
  localparam int WAYS      = 2;
  localparam int PERM_LSB  = 2;
  localparam int PERM_W    = 7;

  typedef enum logic [1:0] {
    SEL_PD0 = 2'd0,
    SEL_PD1 = 2'd1,
    SEL_IDX = 2'd2,
    SEL_CMD = 2'd3
  } sel_e;

  typedef enum logic [2:0] {
    CMD_NOP    = 3'd0,
    CMD_STORE  = 3'd1,
    CMD_FETCH  = 3'd2,
    CMD_SEARCH = 3'd3,
    CMD_PICK   = 3'd4
  } cmd_e;

  typedef struct packed {
    logic ldPd0;
    logic ldPd1;
    logic ldIdx;
    logic doStore;
    logic doFetch;
    logic doSearch;
    logic doPick;
  } strobe_t;

  function automatic logic entryMatch(input logic [PD_W-1:0] ent,
                                      input logic [VPN_W-1:0] vpn,
                                      input logic [ASID_W-1:0] asid);
    return ent[BIT_VLD] && (ent[PD_W-1:PAGE_LSB] == vpn) &&
           (ent[BIT_GLB] || (ent[ASID_W-1:0] == asid));
  endfunction
endpackage

// File: rtl/jtlb_ctrl.sv
module jtlb_ctrl
  import jtlb_pkg::*;
(
  input  logic       regWrEn,
  input  logic [1:0] regSel,
  input  logic [2:0] cmdCode,
  output strobe_t    st
);
  always_comb begin
    st = '0;
    if (regWrEn) begin
      case (regSel)
        SEL_PD0: st.ldPd0 = 1'b1;
        SEL_PD1: st.ldPd1 = 1'b1;
        SEL_IDX: st.ldIdx = 1'b1;
        default: begin
          case (cmdCode)
            CMD_STORE:  st.doStore  = 1'b1;
            CMD_FETCH:  st.doFetch  = 1'b1;
            CMD_SEARCH: st.doSearch = 1'b1;
            CMD_PICK:   st.doPick   = 1'b1;
            default:    ;
          endcase
        end
      endcase
    end
  end
endmodule

// File: rtl/jtlb_way_match.sv
module jtlb_way_match
  import jtlb_pkg::*;
(
  input  logic [WAYS-1:0][PD_W-1:0] ent,
  input  logic [VPN_W-1:0]          vpn,
  input  logic [ASID_W-1:0]         asid,
  output logic [WAYS-1:0]           hit
);
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign hit[w] = entryMatch(ent[w], vpn, asid);
  end
endmodule

// File: rtl/jtlb_datapath.sv
module jtlb_datapath
  import jtlb_pkg::*;
#(
  parameter int SET_BITS = 7
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             st,
  input  logic [PD_W-1:0]     wrData,
  output logic [PD_W-1:0]     pd0Q,
  output logic [PD_W-1:0]     pd1Q,
  output logic [PD_W-1:0]     idxQ,
  input  logic [VPN_W-1:0]    lkVpn,
  input  logic [ASID_W-1:0]   lkAsid,
  output logic                lkHit,
  output logic                lkMulti,
  output logic [VPN_W-1:0]    lkPfn,
  output logic [PERM_W-1:0]   lkPerm
);
  localparam int IDX_W   = SET_BITS + 1;
  localparam int ENTRIES = 1 << IDX_W;
  localparam int SETS    = 1 << SET_BITS;
  localparam int PAD_W   = PD_W - 1 - IDX_W;

  logic [PD_W-1:0]  pd0Mem [ENTRIES];
  logic [PD_W-1:0]  pd1Mem [ENTRIES];
  logic [SETS-1:0]  rotBit;
  logic             idxErr;
  logic [IDX_W-1:0] idxVal;

  logic [SET_BITS-1:0] srchSet, lkSet;
  logic [WAYS-1:0][PD_W-1:0] srchPd0, lkPd0, lkPd1;
  logic [WAYS-1:0] srchHit, lkHitVec;
  logic [PD_W-1:0] lkSelPd1;
  logic            pickWay;
  logic            pickByRot;

  assign srchSet = pd0Q[PAGE_LSB +: SET_BITS];
  assign lkSet   = lkVpn[SET_BITS-1:0];

  for (genvar w = 0; w < WAYS; w++) begin : g_rd
    assign srchPd0[w] = pd0Mem[{srchSet, 1'b0} | IDX_W'(w)];
    assign lkPd0[w]   = pd0Mem[{lkSet, 1'b0} | IDX_W'(w)];
    assign lkPd1[w]   = pd1Mem[{lkSet, 1'b0} | IDX_W'(w)];
  end

  jtlb_way_match u_srchMatch (
    .ent  (srchPd0),
    .vpn  (pd0Q[PD_W-1:PAGE_LSB]),
    .asid (pd0Q[ASID_W-1:0]),
    .hit  (srchHit)
  );

  jtlb_way_match u_lkMatch (
    .ent  (lkPd0),
    .vpn  (lkVpn),
    .asid (lkAsid),
    .hit  (lkHitVec)
  );

  // victim choice: first invalid way, else the set's rotation bit
  always_comb begin
    pickByRot = 1'b0;
    if (!srchPd0[0][BIT_VLD])      pickWay = 1'b0;
    else if (!srchPd0[1][BIT_VLD]) pickWay = 1'b1;
    else begin
      pickWay   = rotBit[srchSet];
      pickByRot = 1'b1;
    end
  end

  assign lkHit    = |lkHitVec;
  assign lkMulti  = &lkHitVec;
  assign lkSelPd1 = lkHitVec[0] ? lkPd1[0] : lkPd1[1];
  assign lkPfn    = lkSelPd1[PD_W-1:PAGE_LSB];
  assign lkPerm   = lkSelPd1[PERM_LSB +: PERM_W];

  logic unusedPd1Bits;
  assign unusedPd1Bits = ^{lkSelPd1[PAGE_LSB-1:PERM_LSB+PERM_W], lkSelPd1[PERM_LSB-1:0]};

  assign idxQ = {idxErr, {PAD_W{1'b0}}, idxVal};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pd0Q   <= '0;
      pd1Q   <= '0;
      idxErr <= 1'b1;
      idxVal <= '0;
      rotBit <= '0;
      for (int e = 0; e < ENTRIES; e++) begin
        pd0Mem[e] <= '0;
        pd1Mem[e] <= '0;
      end
    end else begin
      if (st.ldPd0) pd0Q <= wrData;
      if (st.ldPd1) pd1Q <= wrData;
      if (st.ldIdx) begin
        idxErr <= wrData[ERR_BIT];
        idxVal <= wrData[IDX_W-1:0];
      end
      if (st.doFetch && !idxErr) begin
        pd0Q <= pd0Mem[idxVal];
        pd1Q <= pd1Mem[idxVal];
      end
      if (st.doStore && !idxErr) begin
        pd0Mem[idxVal] <= pd0Q;
        pd1Mem[idxVal] <= pd1Q;
      end
      if (st.doSearch) begin
        case (srchHit)
          2'b01: begin idxErr <= 1'b0; idxVal <= {srchSet, 1'b0}; end
          2'b10: begin idxErr <= 1'b0; idxVal <= {srchSet, 1'b1}; end
          2'b11: begin idxErr <= 1'b1; idxVal <= IDX_W'(1); end
          default: begin idxErr <= 1'b1; idxVal <= '0; end
        endcase
      end
      if (st.doPick) begin
        idxErr <= 1'b0;
        idxVal <= {srchSet, pickWay};
        if (pickByRot) rotBit[srchSet] <= ~rotBit[srchSet];
      end
    end
  end
endmodule

// File: rtl/jtlb_engine.sv
module jtlb_engine
  import jtlb_pkg::*;
#(
  parameter int SET_BITS = 7
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [1:0]  regSel,
  input  logic [31:0] regWrData,
  output logic [31:0] pd0Out,
  output logic [31:0] pd1Out,
  output logic [31:0] indexOut,
  output logic        busy,
  input  logic [18:0] lkVpn,
  input  logic [7:0]  lkAsid,
  output logic        lkHit,
  output logic        lkMulti,
  output logic [18:0] lkPfn,
  output logic [6:0]  lkPerm
);
  strobe_t st;

  jtlb_ctrl u_ctrl (
    .regWrEn (regWrEn),
    .regSel  (regSel),
    .cmdCode (regWrData[2:0]),
    .st      (st)
  );

  jtlb_datapath #(.SET_BITS(SET_BITS)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .st      (st),
    .wrData  (regWrData),
    .pd0Q    (pd0Out),
    .pd1Q    (pd1Out),
    .idxQ    (indexOut),
    .lkVpn   (lkVpn),
    .lkAsid  (lkAsid),
    .lkHit   (lkHit),
    .lkMulti (lkMulti),
    .lkPfn   (lkPfn),
    .lkPerm  (lkPerm)
  );

  assign busy = 1'b0;
endmodule

// File: rtl/jtlb_checker.sv
module jtlb_checker #(
  parameter int SET_BITS = 7
) (
  input logic        clk,
  input logic        rstN,
  input logic        regWrEn,
  input logic [1:0]  regSel,
  input logic [2:0]  cmdCode,
  input logic [31:0] pd0Out,
  input logic [31:0] pd1Out,
  input logic [31:0] indexOut,
  input logic        lkHit,
  input logic        lkMulti
);
  localparam int IDX_W = SET_BITS + 1;

  logic isCmd, isStore, isFetch, isSearch, isPick;
  assign isCmd    = regWrEn && (regSel == 2'd3);
  assign isStore  = isCmd && (cmdCode == 3'd1);
  assign isFetch  = isCmd && (cmdCode == 3'd2);
  assign isSearch = isCmd && (cmdCode == 3'd3);
  assign isPick   = isCmd && (cmdCode == 3'd4);

  AST_SEARCH_CODE: assert property (@(posedge clk) disable iff (!rstN) // R6
    isSearch |=> (indexOut[30:IDX_W] == '0) && (!indexOut[31] || (indexOut[IDX_W-1:1] == '0)));

  AST_SEARCH_SET: assert property (@(posedge clk) disable iff (!rstN) // R5
    isSearch |=> indexOut[31] || (indexOut[IDX_W-1:1] == $past(pd0Out[13 +: SET_BITS])));

  AST_SEARCH_KEEPS_PD: assert property (@(posedge clk) disable iff (!rstN) // R5
    isSearch |=> $stable(pd0Out) && $stable(pd1Out));

  AST_PICK_SET: assert property (@(posedge clk) disable iff (!rstN) // R9
    isPick |=> !indexOut[31] && (indexOut[IDX_W-1:1] == $past(pd0Out[13 +: SET_BITS])));

  AST_STORE_KEEPS_REGS: assert property (@(posedge clk) disable iff (!rstN) // R7
    isStore |=> $stable(pd0Out) && $stable(pd1Out) && $stable(indexOut));

  AST_FETCH_KEEPS_IDX: assert property (@(posedge clk) disable iff (!rstN) // R8
    isFetch |=> $stable(indexOut));

  AST_MULTI_IS_HIT: assert property (@(posedge clk) disable iff (!rstN) // R10
    lkMulti |-> lkHit);

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rstN) // R11
    !regWrEn |=> $stable(pd0Out) && $stable(pd1Out) && $stable(indexOut));
endmodule

bind jtlb_engine jtlb_checker #(.SET_BITS(SET_BITS)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .regWrEn  (regWrEn),
  .regSel   (regSel),
  .cmdCode  (regWrData[2:0]),
  .pd0Out   (pd0Out),
  .pd1Out   (pd1Out),
  .indexOut (indexOut),
  .lkHit    (lkHit),
  .lkMulti  (lkMulti)
);

// File: tb/jtlb_engine_tb_top.sv
module jtlb_engine_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regSel = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] pd0Out, pd1Out, indexOut;
  logic        busy;
  logic [18:0] lkVpn = '0;
  logic [7:0]  lkAsid = '0;
  logic        lkHit, lkMulti;
  logic [18:0] lkPfn;
  logic [6:0]  lkPerm;

  int nChecks = 0;
  int nFails  = 0;

  always #5 clk = ~clk;

  jtlb_engine dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel), .regWrData(regWrData),
    .pd0Out(pd0Out), .pd1Out(pd1Out), .indexOut(indexOut), .busy(busy),
    .lkVpn(lkVpn), .lkAsid(lkAsid), .lkHit(lkHit), .lkMulti(lkMulti),
    .lkPfn(lkPfn), .lkPerm(lkPerm)
  );

  // reference model state
  logic [31:0] mP0 [256];
  logic [31:0] mP1 [256];
  logic        mRot [128];
  logic [31:0] mPd0, mPd1;
  logic        mErr;
  logic [7:0]  mVal;

  function automatic logic mMatch(input logic [31:0] e, input logic [18:0] v, input logic [7:0] a);
    return e[10] && (e[31:13] == v) && (e[8] || (e[7:0] == a));
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic modelApply(input logic [1:0] sel, input logic [31:0] d);
    logic [6:0] s;
    logic h0, h1, w;
    case (sel)
      2'd0: mPd0 = d;
      2'd1: mPd1 = d;
      2'd2: begin mErr = d[31]; mVal = d[7:0]; end
      default: begin
        s = mPd0[19:13];
        case (d[2:0])
          3'd1: if (!mErr) begin mP0[mVal] = mPd0; mP1[mVal] = mPd1; end
          3'd2: if (!mErr) begin mPd0 = mP0[mVal]; mPd1 = mP1[mVal]; end
          3'd3: begin
            h0 = mMatch(mP0[{s, 1'b0}], mPd0[31:13], mPd0[7:0]);
            h1 = mMatch(mP0[{s, 1'b1}], mPd0[31:13], mPd0[7:0]);
            if (h0 && h1)  begin mErr = 1'b1; mVal = 8'd1; end
            else if (h0)   begin mErr = 1'b0; mVal = {s, 1'b0}; end
            else if (h1)   begin mErr = 1'b0; mVal = {s, 1'b1}; end
            else           begin mErr = 1'b1; mVal = 8'd0; end
          end
          3'd4: begin
            if (!mP0[{s, 1'b0}][10])      w = 1'b0;
            else if (!mP0[{s, 1'b1}][10]) w = 1'b1;
            else begin w = mRot[s]; mRot[s] = ~mRot[s]; end
            mErr = 1'b0;
            mVal = {s, w};
          end
          default: ;
        endcase
      end
    endcase
  endtask

  task automatic issue(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regSel = sel; regWrData = d;
    modelApply(sel, d);
  endtask

  task automatic release_bus();
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    issue(sel, d);
    release_bus();
  endtask

  task automatic checkRegs(input string tag);
    chk({tag, " pd0"}, pd0Out, mPd0);
    chk({tag, " pd1"}, pd1Out, mPd1);
    chk({tag, " idx"}, indexOut, {mErr, 23'b0, mVal});
  endtask

  task automatic lk(input string tag, input logic [18:0] v, input logic [7:0] a);
    logic h0, h1;
    logic [31:0] p1;
    lkVpn = v; lkAsid = a;
    #1;
    h0 = mMatch(mP0[{v[6:0], 1'b0}], v, a);
    h1 = mMatch(mP0[{v[6:0], 1'b1}], v, a);
    p1 = h0 ? mP1[{v[6:0], 1'b0}] : mP1[{v[6:0], 1'b1}];
    chk({tag, " hit"}, 32'(lkHit), 32'(h0 | h1));
    chk({tag, " multi"}, 32'(lkMulti), 32'(h0 & h1));
    if (h0 | h1) begin
      chk({tag, " pfn"}, 32'(lkPfn), 32'(p1[31:13]));
      chk({tag, " perm"}, 32'(lkPerm), 32'(p1[8:2]));
    end
  endtask

  localparam logic [31:0] PD0_A = {19'h12345, 13'h0} | 32'h403;
  localparam logic [31:0] PD0_B = {19'h12245, 13'h0} | 32'h509;
  localparam logic [31:0] PD0_C = {19'h12145, 13'h0} | 32'h403;
  localparam logic [31:0] PD1_A = {19'h0ABCD, 13'h0} | 32'h0A4;
  localparam logic [31:0] PD1_C = {19'h00777, 13'h0} | 32'h004;

  initial begin
    for (int i = 0; i < 256; i++) begin mP0[i] = '0; mP1[i] = '0; end
    for (int i = 0; i < 128; i++) mRot[i] = 1'b0;
    mPd0 = '0; mPd1 = '0; mErr = 1'b1; mVal = '0;
    void'($urandom(32'd20240611));

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 pd0", pd0Out, 32'h0);
    chk("R1 pd1", pd1Out, 32'h0);
    chk("R1 idx", indexOut, 32'h8000_0000);
    chk("R1 busy", 32'(busy), 32'h0);
    lk("R1 lookup empty", 19'h12345, 8'd3);

    // R6 miss, R9 invalid way first, R3 slot layout
    wr(2'd0, PD0_A);
    wr(2'd3, 32'd3);
    chk("R6 search miss", indexOut, 32'h8000_0000);
    wr(2'd3, 32'd4);
    chk("R9 pick way0 / R3 set 0x45", indexOut, 32'h0000_008A);
    wr(2'd1, PD1_A);
    wr(2'd3, 32'd1);
    checkRegs("R7 store keeps regs");
    lkVpn = 19'h12345; lkAsid = 8'd3; #1;
    chk("R10 hit", 32'(lkHit), 32'd1);
    chk("R10 pfn", 32'(lkPfn), 32'h0ABCD);
    chk("R10 perm", 32'(lkPerm), 32'h29);
    lkAsid = 8'd4; #1;
    chk("R4 asid mismatch", 32'(lkHit), 32'd0);
    wr(2'd3, 32'd3);
    chk("R5 search hit", indexOut, 32'h0000_008A);

    // global entry in way 1
    wr(2'd0, PD0_B);
    wr(2'd3, 32'd3);
    chk("R6 search miss B", indexOut, 32'h8000_0000);
    wr(2'd3, 32'd4);
    chk("R9 pick way1", indexOut, 32'h0000_008B);
    wr(2'd3, 32'd1);
    lkVpn = 19'h12245; lkAsid = 8'h55; #1;
    chk("R4 global any asid", 32'(lkHit), 32'd1);

    // full set: rotation
    wr(2'd0, PD0_C);
    wr(2'd1, PD1_C);
    wr(2'd3, 32'd4);
    chk("R9 rotation first", indexOut, 32'h0000_008A);
    wr(2'd3, 32'd1);
    lk("R9 victim evicted", 19'h12345, 8'd3);
    chk("R9 A gone", 32'(lkHit), 32'd0);
    wr(2'd3, 32'd4);
    chk("R9 rotation toggled", indexOut, 32'h0000_008B);
    wr(2'd3, 32'd1);
    wr(2'd3, 32'd3);
    chk("R6 duplicate", indexOut, 32'h8000_0001);
    lkVpn = 19'h12145; lkAsid = 8'd3; #1;
    chk("R10 multi", 32'(lkMulti), 32'd1);
    chk("R10 multi pfn", 32'(lkPfn), 32'h00777);

    // erase way 1
    wr(2'd2, 32'h8B);
    wr(2'd0, 32'h0);
    wr(2'd1, 32'h0);
    wr(2'd3, 32'd1);
    wr(2'd0, PD0_C);
    wr(2'd3, 32'd3);
    chk("R7 erase leaves single", indexOut, 32'h0000_008A);
    lk("R7 erase lookup", 19'h12145, 8'd3);

    // fetch and error-flag gating
    wr(2'd0, 32'h0);
    wr(2'd1, 32'h0);
    wr(2'd3, 32'd2);
    chk("R8 fetch pd0", pd0Out, PD0_C);
    chk("R8 fetch pd1", pd1Out, PD1_C);
    wr(2'd2, 32'h8000_008A);
    wr(2'd0, PD0_A);
    wr(2'd3, 32'd1);
    wr(2'd2, 32'h8A);
    wr(2'd3, 32'd2);
    chk("R7 store ignored on error", pd0Out, PD0_C);
    wr(2'd2, 32'h8000_008A);
    wr(2'd0, 32'h1234);
    wr(2'd3, 32'd2);
    chk("R8 fetch ignored on error", pd0Out, 32'h1234);

    // index masking and no-op codes
    wr(2'd2, 32'hFFFF_FF12);
    chk("R2 index mask", indexOut, 32'h8000_0012);
    wr(2'd3, 32'd0);
    wr(2'd3, 32'd7);
    wr(2'd3, 32'd5);
    checkRegs("R2 nop codes");
    lk("R2 nop lookup", 19'h12145, 8'd3);

    // back to back commands
    issue(2'd0, PD0_A);
    issue(2'd3, 32'd3);
    issue(2'd3, 32'd4);
    release_bus();
    chk("R11 back to back", indexOut, 32'h0000_008B);
    chk("R11 busy", 32'(busy), 32'h0);
    checkRegs("R11 regs");

    // constrained random phase
    for (int n = 0; n < 3000; n++) begin
      int unsigned k = $urandom % 10;
      logic [18:0] v;
      logic [7:0]  a;
      logic [31:0] d;
      v = {(($urandom % 4) == 0) ? 12'h000 : (($urandom % 3) == 0) ? 12'h155 :
           (($urandom % 2) == 0) ? 12'hAAA : 12'hFFF,
           (($urandom % 2) == 0) ? 7'h45 : 7'h10};
      a = (($urandom % 2) == 0) ? 8'd3 : 8'd4;
      if (k < 2) begin
        d = {v, 13'h0} | {21'h0, (($urandom % 5) != 0), 10'h0} |
            {23'h0, (($urandom % 4) == 0), 8'h0} | 32'(a) | ($urandom & 32'h1A00);
        wr(2'd0, d);
        checkRegs("R2 rand pd0");
      end else if (k == 2) begin
        wr(2'd1, $urandom);
        checkRegs("R2 rand pd1");
      end else if (k == 3) begin
        wr(2'd2, $urandom & 32'h8000_00FF);
        checkRegs("R2 rand idx");
      end else if (k == 4) begin
        wr(2'd3, 32'd1);
        checkRegs("R7 rand store");
      end else if (k == 5) begin
        wr(2'd3, 32'd2);
        checkRegs("R8 rand fetch");
      end else if (k < 8) begin
        wr(2'd3, 32'd3);
        checkRegs("R5 R6 rand search");
      end else begin
        wr(2'd3, 32'd4);
        checkRegs("R9 rand pick");
      end
      lk("R10 rand lookup", v, a);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    #(10 * 200000);
    nChecks++;
    nFails++;
    $display("FAIL R11 watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule